// File: doc/BRIEF.md
# Two-Way Lockable Instruction Cache

This block is an 8 KB instruction cache controller organized as two ways of 256 sets with four 32-bit words per line. The core presents a word address with a request and holds both until the cache answers with ready and the instruction word. A hit answers in the same cycle. A miss starts one burst read on the bus side. The bus returns the four words of the line starting with the requested word and wrapping around to the start of the line. The requested word goes to the core in the cycle it arrives. The other three words fill the line in the background.

Software drives an enable, a flush-everything strobe, a flush-one-line strobe with an address, and a lock control. Lines filled while the lock control is high become locked. A locked line is never picked for replacement and is not removed by the single-line flush. When the cache is disabled, the same data storage acts as plain on-chip RAM through the fetch port. Each set keeps one least-recently-used bit.

Top module: `icache_2way`

## Requirements
- R1: After reset every line is invalid and no burst is requested. The first enabled fetch to any address misses.
- R2: A fetch hits when a valid way of the set selected by address bits 11:4 holds a tag equal to address bits 30:12. `f_ready` then rises in the same cycle, and `f_data` is the word selected by address bits 3:2.
- R3: A miss raises `b_req` for exactly one cycle. `b_addr` is the missed word's address with bits 1:0 zero. The bus then returns four words, starting with the requested word and stepping through the line with wraparound. Each word is stored in its own slot of the line.
- R4: On a miss, `f_ready` rises in the cycle the first burst word is valid on the bus, and `f_data` equals that bus word. A miss with the bus answering at once therefore completes two cycles after the cycle of the request.
- R5: During a fill, a fetch to the line being filled is answered once its word has been written, and is stalled before then. A fetch to any other line stalls until the fill ends.
- R6: The victim is an invalid unlocked way, with way 0 checked before way 1. If both ways are valid and unlocked, the way not used most recently is replaced. Every hit and every fill updates the recency bit of its set.
- R7: A line filled while `lock_fill` is high becomes locked, and a miss never replaces a locked line.
- R8: When both ways of a set are locked, a miss is still answered from the bus but no line is allocated, so the same fetch misses again.
- R9: A `flush_line` pulse invalidates the way whose valid tag matches `flush_addr` in its set, unless that way is locked.
- R10: A `flush_all` pulse clears the valid and lock bits of every line.
- R11: With `cfg_enable` low, a fetch reads the storage as RAM, with bit 12 choosing the way and bits 11:2 the word, and is ready in the same cycle. With `ram_wr` also high, it writes `ram_wdata` to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Cache enable; low selects RAM mode |
| lock_fill | input | 1 | Lines filled while high become locked |
| flush_all | input | 1 | Pulse: invalidate and unlock every line |
| flush_line | input | 1 | Pulse: invalidate the unlocked line matching flush_addr |
| flush_addr | input | 32 | Address for the single-line flush |
| f_req | input | 1 | Fetch request, held until f_ready |
| f_addr | input | 32 | Fetch byte address |
| ram_wr | input | 1 | RAM-mode write qualifier for a fetch-port access |
| ram_wdata | input | 32 | RAM-mode write data |
| f_ready | output | 1 | Fetch answered this cycle |
| f_data | output | 32 | Instruction word |
| b_req | output | 1 | One-cycle burst read request |
| b_addr | output | 32 | Critical word address of the burst |
| b_valid | input | 1 | Burst word valid |
| b_last | input | 1 | Final word of the burst |
| b_data | input | 32 | Burst word |

## Verification
The bench goes after the wrap order by missing in the middle of a line and then reading every other word of that line as a hit. A design that stored words in arrival order would return wrong data on those hits. It checks the victim choice by exact hit and miss latencies after a hit has refreshed one way. A design that ignored recency, or preferred a valid way over an empty one, would evict the line that must survive. It fills both ways of a set as locked, then checks that a third tag misses twice while both locked lines still hit. It also checks that a single-line flush leaves a locked line in place while `flush_all` unlocks it. Finally, a fetch for a later word of a line still being filled must wait exactly until that word is written. A design that looked only at the tag would answer too early, with stale data.

// File: rtl/icache_pkg.sv
package icache_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FILL  = 2'd2
    } ic_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int SET_W = 8,
    parameter int TAG_W = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      rd_set,
    output logic [1:0]            rd_valid,
    output logic [1:0]            rd_lock,
    output logic [1:0][TAG_W-1:0] rd_tag,
    output logic                  rd_lru,
    input  logic                  flush_all,
    input  logic                  flush_one,
    input  logic [SET_W-1:0]      flush_set,
    input  logic [TAG_W-1:0]      flush_tag,
    input  logic                  touch_en,
    input  logic                  touch_way,
    input  logic [SET_W-1:0]      touch_set,
    input  logic                  inst_en,
    input  logic                  inst_way,
    input  logic [SET_W-1:0]      inst_set,
    input  logic [TAG_W-1:0]      inst_tag,
    input  logic                  inst_lock
);
    localparam int SETS = 1 << SET_W;

    logic [1:0]            valid_q [SETS];
    logic [1:0]            lock_q  [SETS];
    logic                  lru_q   [SETS];
    logic [1:0][TAG_W-1:0] tag_q   [SETS];

    assign rd_valid = valid_q[rd_set];
    assign rd_lock  = lock_q[rd_set];
    assign rd_tag   = tag_q[rd_set];
    assign rd_lru   = lru_q[rd_set];

    // state bits: flush first, then recency, then install (later wins)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lock_q[s]  <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (flush_all) begin
                for (int s = 0; s < SETS; s++) begin
                    valid_q[s] <= '0;
                    lock_q[s]  <= '0;
                end
            end else if (flush_one) begin
                for (int w = 0; w < 2; w++) begin
                    if (valid_q[flush_set][w] && !lock_q[flush_set][w] &&
                        tag_q[flush_set][w] == flush_tag) begin
                        valid_q[flush_set][w] <= 1'b0;
                    end
                end
            end
            if (touch_en) begin
                lru_q[touch_set] <= ~touch_way;
            end
            if (inst_en) begin
                valid_q[inst_set][inst_way] <= 1'b1;
                lock_q[inst_set][inst_way]  <= inst_lock;
                lru_q[inst_set]             <= ~inst_way;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) begin
            tag_q[inst_set][inst_way] <= inst_tag;
        end
    end
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int SET_W  = 8,
    parameter int WSEL_W = 2,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [SET_W-1:0]       wr_set,
    input  logic [WSEL_W-1:0]      wr_word,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [SET_W-1:0]       rd_set,
    input  logic [WSEL_W-1:0]      rd_word,
    output logic [1:0][DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << (SET_W + WSEL_W);

    for (genvar g = 0; g < icache_pkg::NUM_WAYS; g++) begin : g_way
        logic [DATA_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(g))) begin
                mem[{wr_set, wr_word}] <= wr_data;
            end
        end

        assign rd_data[g] = mem[{rd_set, rd_word}];
    end
endmodule

// File: rtl/icache_victim.sv
module icache_victim (
    input  logic [1:0] valid,
    input  logic [1:0] lock,
    input  logic       lru,
    output logic       way,
    output logic       alloc
);
    logic [1:0] free;

    always_comb begin
        free  = ~lock;
        way   = 1'b0;
        alloc = 1'b1;
        if (free[0] && !valid[0]) begin
            way = 1'b0;
        end else if (free[1] && !valid[1]) begin
            way = 1'b1;
        end else if (&free) begin
            way = lru;
        end else if (free[0]) begin
            way = 1'b0;
        end else if (free[1]) begin
            way = 1'b1;
        end else begin
            alloc = 1'b0;
        end
    end
endmodule

// File: rtl/icache_2way.sv
module icache_2way #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SET_W  = 8,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              lock_fill,
    input  logic              flush_all,
    input  logic              flush_line,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              f_req,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic              ram_wr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic              f_ready,
    output logic [DATA_W-1:0] f_data,
    output logic              b_req,
    output logic [ADDR_W-1:0] b_addr,
    input  logic              b_valid,
    input  logic              b_last,
    input  logic [DATA_W-1:0] b_data
);
    import icache_pkg::*;

    localparam int BYTE_W = 2;
    localparam int WORDS  = 1 << WSEL_W;
    localparam int SET_LO = BYTE_W + WSEL_W;
    localparam int TAG_LO = SET_LO + SET_W;
    localparam int TAG_W  = ADDR_W - 1 - TAG_LO;
    localparam int WA_W   = ADDR_W - BYTE_W;

    typedef struct packed {
        ic_state_e          st;
        logic [WA_W-1:0]    waddr;
        logic [WSEL_W-1:0]  cnt;
        logic               way;
        logic               alloc;
        logic               lock;
        logic [WORDS-1:0]   filled;
        logic               served;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // fetch address fields
    logic [TAG_W-1:0]  f_tag;
    logic [SET_W-1:0]  f_set;
    logic [WSEL_W-1:0] f_word;
    logic              f_ram_way;
    assign f_tag     = f_addr[ADDR_W-2:TAG_LO];
    assign f_set     = f_addr[TAG_LO-1:SET_LO];
    assign f_word    = f_addr[SET_LO-1:BYTE_W];
    assign f_ram_way = f_addr[TAG_LO];

    // fill line fields
    logic [SET_W-1:0]  l_set;
    logic [TAG_W-1:0]  l_tag;
    logic [WSEL_W-1:0] l_crit;
    logic [WSEL_W-1:0] l_slot;
    logic              same_line;
    assign l_crit    = ctl_q.waddr[WSEL_W-1:0];
    assign l_set     = ctl_q.waddr[WSEL_W +: SET_W];
    assign l_tag     = ctl_q.waddr[WSEL_W + SET_W +: TAG_W];
    assign l_slot    = l_crit + ctl_q.cnt;
    assign same_line = (f_addr[ADDR_W-1:SET_LO] == ctl_q.waddr[WA_W-1:WSEL_W]);

    // tag store hookup
    logic [1:0]            t_valid, t_lock;
    logic [1:0][TAG_W-1:0] t_tag;
    logic                  t_lru;
    logic                  touch_en, touch_way, inst_en;
    logic [1:0]            hit_way;
    logic                  hit;

    icache_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (f_set),
        .rd_valid  (t_valid),
        .rd_lock   (t_lock),
        .rd_tag    (t_tag),
        .rd_lru    (t_lru),
        .flush_all (flush_all),
        .flush_one (flush_line),
        .flush_set (flush_addr[TAG_LO-1:SET_LO]),
        .flush_tag (flush_addr[ADDR_W-2:TAG_LO]),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .touch_set (f_set),
        .inst_en   (inst_en),
        .inst_way  (ctl_q.way),
        .inst_set  (l_set),
        .inst_tag  (l_tag),
        .inst_lock (ctl_q.lock)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_way[w] = t_valid[w] && (t_tag[w] == f_tag);
    end
    assign hit = |hit_way;

    // victim choice
    logic vic_way, vic_alloc;
    icache_victim u_victim (
        .valid (t_valid),
        .lock  (t_lock),
        .lru   (t_lru),
        .way   (vic_way),
        .alloc (vic_alloc)
    );

    // data store hookup
    logic                   d_wr_en, d_wr_way;
    logic [SET_W-1:0]       d_wr_set;
    logic [WSEL_W-1:0]      d_wr_word;
    logic [DATA_W-1:0]      d_wr_data;
    logic [1:0][DATA_W-1:0] d_rd;

    icache_data_store #(.SET_W(SET_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (d_wr_en),
        .wr_way  (d_wr_way),
        .wr_set  (d_wr_set),
        .wr_word (d_wr_word),
        .wr_data (d_wr_data),
        .rd_set  (f_set),
        .rd_word (f_word),
        .rd_data (d_rd)
    );

    // next-state logic
    always_comb begin
        ctl_d     = ctl_q;
        f_ready   = 1'b0;
        f_data    = d_rd[hit_way[1]];
        touch_en  = 1'b0;
        touch_way = hit_way[1];
        inst_en   = 1'b0;
        d_wr_en   = 1'b0;
        d_wr_way  = ctl_q.way;
        d_wr_set  = l_set;
        d_wr_word = l_slot;
        d_wr_data = b_data;

        case (ctl_q.st)
            ST_IDLE: begin
                if (!cfg_enable) begin
                    if (f_req) begin
                        f_ready   = 1'b1;
                        f_data    = d_rd[f_ram_way];
                        d_wr_en   = ram_wr;
                        d_wr_way  = f_ram_way;
                        d_wr_set  = f_set;
                        d_wr_word = f_word;
                        d_wr_data = ram_wdata;
                    end
                end else if (f_req) begin
                    if (hit) begin
                        f_ready  = 1'b1;
                        touch_en = 1'b1;
                    end else begin
                        ctl_d.st     = ST_ISSUE;
                        ctl_d.waddr  = f_addr[ADDR_W-1:BYTE_W];
                        ctl_d.cnt    = '0;
                        ctl_d.way    = vic_way;
                        ctl_d.alloc  = vic_alloc;
                        ctl_d.lock   = lock_fill;
                        ctl_d.filled = '0;
                        ctl_d.served = 1'b0;
                    end
                end
            end
            ST_ISSUE: begin
                ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (ctl_q.served && f_req && same_line && ctl_q.alloc &&
                    ctl_q.filled[f_word]) begin
                    f_ready = 1'b1;
                    f_data  = d_rd[ctl_q.way];
                end
                if (b_valid) begin
                    d_wr_en              = ctl_q.alloc;
                    ctl_d.filled[l_slot] = 1'b1;
                    ctl_d.cnt            = ctl_q.cnt + 1'b1;
                    if (!ctl_q.served) begin
                        f_ready      = f_req;
                        f_data       = b_data;
                        ctl_d.served = 1'b1;
                    end
                    if (b_last) begin
                        inst_en  = ctl_q.alloc;
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign b_req  = (ctl_q.st == ST_ISSUE);
    assign b_addr = {ctl_q.waddr, {BYTE_W{1'b0}}};

    logic unused_bits;
    assign unused_bits = ^{f_addr[BYTE_W-1:0], flush_addr[SET_LO-1:0],
                           flush_addr[ADDR_W-1]};
endmodule

// File: rtl/icache_2way_chk.sv
module icache_2way_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       f_req,
    input logic       f_ready,
    input logic       b_req,
    input logic [1:0] hit_way
);
    // R3: burst request lasts one cycle
    a_r3_breq_single: assert property (@(posedge clk) disable iff (!rst_n)
        b_req |=> !b_req);

    // R3: a burst only starts for a fetch that was pending
    a_r3_breq_has_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_req) |-> $past(f_req));

    // R4: ready is only given to a pending fetch
    a_r4_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        f_ready |-> f_req);

    // R2: a line lives in at most one way
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        f_req |-> $onehot0(hit_way));
endmodule

bind icache_2way icache_2way_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_req   (f_req),
    .f_ready (f_ready),
    .b_req   (b_req),
    .hit_way (hit_way)
);

// File: tb/icache_2way_tb_top.sv
`timescale 1ns/1ps
module icache_2way_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, lock_fill = 1'b0;
    logic        flush_all = 1'b0, flush_line = 1'b0;
    logic [31:0] flush_addr = '0;
    logic        f_req = 1'b0, ram_wr = 1'b0;
    logic [31:0] f_addr = '0, ram_wdata = '0;
    logic        f_ready, b_req;
    logic [31:0] f_data, b_addr;
    logic        b_valid = 1'b0, b_last = 1'b0;
    logic [31:0] b_data = '0;
    logic [31:0] last_baddr = '0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    icache_2way dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .lock_fill(lock_fill),
        .flush_all(flush_all), .flush_line(flush_line), .flush_addr(flush_addr),
        .f_req(f_req), .f_addr(f_addr), .ram_wr(ram_wr), .ram_wdata(ram_wdata),
        .f_ready(f_ready), .f_data(f_data), .b_req(b_req), .b_addr(b_addr),
        .b_valid(b_valid), .b_last(b_last), .b_data(b_data)
    );

    function automatic logic [31:0] mw(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_A5A5;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return {1'b0, 19'(tag), 8'(set), 2'(word), 2'b00};
    endfunction

    // behavioural memory: one burst per request, critical word first, wrapping
    initial begin
        forever begin
            @(negedge clk);
            if (b_req) begin
                last_baddr = b_addr;
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    b_valid = 1'b1;
                    b_data  = mw({b_addr[31:4], 2'(b_addr[3:2] + 2'(i)), 2'b00});
                    b_last  = (i == 3);
                end
                @(negedge clk);
                b_valid = 1'b0;
                b_last  = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, output int w, output logic [31:0] d);
        f_addr = a;
        f_req  = 1'b1;
        w = 0;
        #1;
        while (!f_ready && w < 60) begin
            @(negedge clk);
            #1;
            w++;
        end
        d = f_data;
        @(negedge clk);
        f_req = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // fetch and check latency (0 = hit, 2 = miss) and data
    task automatic expect_fetch(input logic [31:0] a, input int exp_w, input string req);
        int w;
        logic [31:0] d;
        fetch(a, w, d);
        chk(w == exp_w, req, 32'(w), 32'(exp_w));
        chk(d == mw(a), req, d, mw(a));
        settle();
    endtask

    task automatic pulse_flush_line(input logic [31:0] a);
        flush_addr = a;
        flush_line = 1'b1;
        @(negedge clk);
        flush_line = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(b_req == 1'b0, "R1 no burst after reset", 32'(b_req), 0);
        chk(f_ready == 1'b0, "R1 idle ready", 32'(f_ready), 0);
    endtask

    task automatic t_ram_mode();
        logic [31:0] a1, a0;
        a1 = 32'h0000_1A48;
        a0 = 32'h0000_0A48;
        f_addr = a1; ram_wdata = 32'hDEAD_BEEF; ram_wr = 1'b1; f_req = 1'b1;
        #1;
        chk(f_ready == 1'b1, "R11 write ready", 32'(f_ready), 1);
        @(negedge clk);
        f_addr = a0; ram_wdata = 32'h1234_5678;
        @(negedge clk);
        ram_wr = 1'b0; f_addr = a1;
        #1;
        chk(f_ready == 1'b1, "R11 read ready", 32'(f_ready), 1);
        chk(f_data == 32'hDEAD_BEEF, "R11 way1 word", f_data, 32'hDEAD_BEEF);
        @(negedge clk);
        f_addr = a0;
        #1;
        chk(f_data == 32'h1234_5678, "R11 way0 word", f_data, 32'h1234_5678);
        @(negedge clk);
        f_req = 1'b0;
        chk(b_req == 1'b0, "R11 no burst when disabled", 32'(b_req), 0);
    endtask

    task automatic t_miss_wrap();
        int w;
        logic [31:0] d;
        fetch(mk(1, 5, 2), w, d);
        chk(w == 2, "R1 R4 first fetch misses", 32'(w), 2);
        chk(d == mw(mk(1, 5, 2)), "R4 critical word", d, mw(mk(1, 5, 2)));
        chk(last_baddr == mk(1, 5, 2), "R3 burst address", last_baddr, mk(1, 5, 2));
        settle();
        expect_fetch(mk(1, 5, 0), 0, "R3 R2 wrapped word 0");
        expect_fetch(mk(1, 5, 1), 0, "R3 R2 wrapped word 1");
        expect_fetch(mk(1, 5, 3), 0, "R3 R2 word 3");
        expect_fetch(mk(1, 5, 2), 0, "R2 critical word hit");
    endtask

    task automatic t_stall_fill();
        int w;
        logic [31:0] d;
        fetch(mk(1, 40, 1), w, d);
        chk(w == 2, "R5 miss", 32'(w), 2);
        fetch(mk(1, 40, 3), w, d);
        chk(w == 2, "R5 stall until word written", 32'(w), 2);
        chk(d == mw(mk(1, 40, 3)), "R5 data after stall", d, mw(mk(1, 40, 3)));
        settle();
    endtask

    task automatic t_lru();
        expect_fetch(mk(1, 9, 0), 2, "R6 fill A");
        expect_fetch(mk(2, 9, 0), 2, "R6 fill B invalid way");
        expect_fetch(mk(1, 9, 0), 0, "R6 A kept (invalid preferred)");
        expect_fetch(mk(3, 9, 0), 2, "R6 C replaces LRU");
        expect_fetch(mk(1, 9, 0), 0, "R6 recent A survives");
        expect_fetch(mk(2, 9, 0), 2, "R6 B was evicted");
    endtask

    task automatic t_lock();
        lock_fill = 1'b1;
        expect_fetch(mk(1, 20, 1), 2, "R7 locked fill D");
        lock_fill = 1'b0;
        expect_fetch(mk(2, 20, 0), 2, "R7 fill E");
        expect_fetch(mk(3, 20, 0), 2, "R7 F replaces E");
        expect_fetch(mk(1, 20, 1), 0, "R7 locked D survives");
        expect_fetch(mk(2, 20, 0), 2, "R7 E refills free way");
        pulse_flush_line(mk(1, 20, 0));
        expect_fetch(mk(1, 20, 1), 0, "R9 locked D ignores line flush");
        pulse_flush_line(mk(2, 20, 0));
        expect_fetch(mk(2, 20, 0), 2, "R9 unlocked E flushed");
    endtask

    task automatic t_both_locked();
        lock_fill = 1'b1;
        expect_fetch(mk(1, 30, 0), 2, "R8 lock G");
        expect_fetch(mk(2, 30, 0), 2, "R8 lock H");
        lock_fill = 1'b0;
        expect_fetch(mk(3, 30, 0), 2, "R8 I served from bus");
        expect_fetch(mk(3, 30, 0), 2, "R8 I not allocated");
        expect_fetch(mk(1, 30, 0), 0, "R8 G kept");
        expect_fetch(mk(2, 30, 0), 0, "R8 H kept");
    endtask

    task automatic t_flush_all();
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        @(negedge clk);
        expect_fetch(mk(1, 9, 0), 2, "R10 valid cleared");
        expect_fetch(mk(1, 30, 0), 2, "R10 G refill");
        expect_fetch(mk(2, 30, 0), 2, "R10 H refill");
        expect_fetch(mk(4, 30, 0), 2, "R10 K miss");
        expect_fetch(mk(4, 30, 0), 0, "R10 locks cleared, K allocated");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram_mode();
        cfg_enable = 1'b1;
        @(negedge clk);
        t_miss_wrap();
        t_stall_fill();
        t_lru();
        t_lock();
        t_both_locked();
        t_flush_all();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule